// File: doc/BRIEF.md
# Exception Entry State Generator

This block produces the machine state that a core installs when it enters an exception handler or a system-call handler. For each entry request it takes the current 64-bit machine state register (MSR), the address of the current instruction, a kind select (trap or system call), a 5-bit trap-cause vector and a vector-address field. From these it produces four values:

- the new MSR;
- the return address, saved in SRR0;
- the saved machine state, saved in SRR1;
- the address of the next instruction to fetch.

Each of the four values comes with its own valid flag. Every output is registered, so the results appear one clock after the request is sampled.

Bits are numbered architecturally: bit 0 is the most significant bit of the 64-bit word, so architectural bit n sits at vector position 63-n. The block changes only the MSR fields that the privileged state needs. It does not model hypervisor or transactional-memory semantics.

Top module: `exc_entry_gen`

## Requirements
- R1: Each listed field of the new MSR reads 0; every other field is taken from the current MSR, except as R2 states. The listed fields and their architectural bit numbers are: SF 0 and LE 63 are handled by R2; TM 31, VEC 38, VSX 40, EE 48, PR 49, FP 50, FE0 52, TE 53 to 54, FE1 55, IR 58, DR 59, PMM 61, RI 62, and UND at bit UND_BIT (default 5).
- R2: Bit 0 (SF, vector position 63) and bit 63 (LE, vector position 0) of the new MSR are always 1.
- R3: Every new-MSR bit not named in R1 or R2 equals the same bit of the current MSR. This holds for both entry kinds.
- R4: When kind_i is 0 (trap), SRR0 equals the current instruction address.
- R5: When kind_i is 1 (system call), SRR0 equals the current instruction address plus 4, wrapped modulo 2^64.
- R6: On a trap, SRR1 is a copy of the current MSR with these changes:
  - bits 33 to 36 and bit 42 are 0;
  - bit 43 takes cause bit 0;
  - bit 44 takes cause bit 4;
  - bit 45 takes cause bit 1;
  - bit 47 takes cause bit 3.
- R7: On a trap, SRR1 bit 46 is 1 exactly when the whole cause vector is zero. Cause bit 2 affects no SRR1 bit.
- R8: On a system call, SRR1 bits 33 to 36 and 42 to 47 are 0. Bits 0 to 32, 37 to 41 and 48 to 63 are copied from the current MSR. The cause vector has no effect.
- R9: For both kinds, the next address is the vector-address field, zero-extended and shifted left by 4 bits.
- R10: All four valid flags are 1 in the cycle after a request is sampled, and 0 in the cycle after a clock with no request. They are also 0 during reset and after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| entry_vld_i | input | 1 | Entry request for this cycle |
| kind_i | input | 1 | 0 selects a trap, 1 selects a system call |
| msr_i | input | 64 | Current MSR |
| cia_i | input | 64 | Address of the current instruction |
| cause_i | input | 5 | Trap-cause vector |
| vec_i | input | VEC_W | Vector-address field |
| msr_o | output | 64 | New MSR |
| msr_vld_o | output | 1 | New MSR is valid |
| srr0_o | output | 64 | Saved return address |
| srr0_vld_o | output | 1 | SRR0 is valid |
| srr1_o | output | 64 | Saved machine state |
| srr1_vld_o | output | 1 | SRR1 is valid |
| nia_o | output | 64 | Next instruction address |
| nia_vld_o | output | 1 | Next address is valid |

## Verification
The data path from input to output contains exactly one register. All four results and their valid flags are therefore due one clock edge after the request is sampled, and none of them is due earlier. The bench changes inputs on the falling edge and samples shortly after the next rising edge, so each check compares the values captured from the request driven just before that edge. Idle cycles are sampled the same way to confirm that the valid flags drop one edge after the request goes away.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN = 64;

  // architectural (MSB = 0) bit numbers
  localparam int B_SF  = 0;
  localparam int B_TM  = 31;
  localparam int B_VEC = 38;
  localparam int B_VSX = 40;
  localparam int B_EE  = 48;
  localparam int B_PR  = 49;
  localparam int B_FP  = 50;
  localparam int B_FE0 = 52;
  localparam int B_TE0 = 53;
  localparam int B_TE1 = 54;
  localparam int B_FE1 = 55;
  localparam int B_IR  = 58;
  localparam int B_DR  = 59;
  localparam int B_PMM = 61;
  localparam int B_RI  = 62;
  localparam int B_LE  = 63;

  typedef enum logic {KIND_TRAP = 1'b0, KIND_SC = 1'b1} entry_kind_e;

  typedef struct packed {
    logic [XLEN-1:0] msr;
    logic [XLEN-1:0] srr0;
    logic [XLEN-1:0] srr1;
    logic [XLEN-1:0] nia;
  } entry_state_t;

  // architectural bit n -> vector position
  function automatic int be(input int n);
    return XLEN - 1 - n;
  endfunction

  function automatic logic [XLEN-1:0] be_range(input int lo, input int hi);
    logic [XLEN-1:0] m;
    m = '0;
    for (int n = lo; n <= hi; n++) m[be(n)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/exc_msr_gen.sv
module exc_msr_gen
  import exc_entry_pkg::*;
#(
  parameter int UND_BIT = 5
) (
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] msr_o
);
  function automatic logic [XLEN-1:0] clr_mask(input int und);
    logic [XLEN-1:0] m;
    m = '0;
    m[be(B_TM)]  = 1'b1;
    m[be(B_VEC)] = 1'b1;
    m[be(B_VSX)] = 1'b1;
    m[be(B_EE)]  = 1'b1;
    m[be(B_PR)]  = 1'b1;
    m[be(B_FP)]  = 1'b1;
    m[be(B_FE0)] = 1'b1;
    m[be(B_FE1)] = 1'b1;
    m[be(B_IR)]  = 1'b1;
    m[be(B_DR)]  = 1'b1;
    m[be(B_PMM)] = 1'b1;
    m[be(B_RI)]  = 1'b1;
    m[be(und)]   = 1'b1;
    m = m | be_range(B_TE0, B_TE1);
    return m;
  endfunction

  function automatic logic [XLEN-1:0] set_mask();
    logic [XLEN-1:0] m;
    m = '0;
    m[be(B_SF)] = 1'b1;
    m[be(B_LE)] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] ClrMask = clr_mask(UND_BIT);
  localparam logic [XLEN-1:0] SetMask = set_mask();

  assign msr_o = (msr_i & ~ClrMask) | SetMask;
endmodule

// File: rtl/exc_srr1_gen.sv
module exc_srr1_gen
  import exc_entry_pkg::*;
(
  input  logic            kind_i,
  input  logic [XLEN-1:0] msr_i,
  input  logic [4:0]      cause_i,
  output logic [XLEN-1:0] srr1_o
);
  localparam logic [XLEN-1:0] TrapClr = be_range(33, 36) | be_range(42, 47);
  localparam logic [XLEN-1:0] ScClr   = be_range(33, 36) | be_range(42, 47);

  logic [XLEN-1:0] trap_v, sc_v;

  always_comb begin
    trap_v         = msr_i & ~TrapClr;
    trap_v[be(43)] = cause_i[0];
    trap_v[be(44)] = cause_i[4];
    trap_v[be(45)] = cause_i[1];
    trap_v[be(46)] = (cause_i == 5'd0);
    trap_v[be(47)] = cause_i[3];
    sc_v           = msr_i & ~ScClr;
  end

  assign srr1_o = (entry_kind_e'(kind_i) == KIND_SC) ? sc_v : trap_v;
endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen
  import exc_entry_pkg::*;
#(
  parameter int VEC_W = 60
) (
  input  logic             kind_i,
  input  logic [XLEN-1:0]  cia_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [XLEN-1:0]  srr0_o,
  output logic [XLEN-1:0]  nia_o
);
  localparam int SH = 4;
  localparam logic [XLEN-1:0] InsnBytes = XLEN'(4);

  logic [XLEN-1:0] vec_ext;
  assign vec_ext = XLEN'(vec_i);
  assign nia_o   = vec_ext << SH;
  assign srr0_o  = (entry_kind_e'(kind_i) == KIND_SC) ? cia_i + InsnBytes : cia_i;
endmodule

// File: rtl/exc_entry_gen.sv
module exc_entry_gen
  import exc_entry_pkg::*;
#(
  parameter int VEC_W   = 60,
  parameter int UND_BIT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_vld_i,
  input  logic             kind_i,
  input  logic [63:0]      msr_i,
  input  logic [63:0]      cia_i,
  input  logic [4:0]       cause_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [63:0]      msr_o,
  output logic             msr_vld_o,
  output logic [63:0]      srr0_o,
  output logic             srr0_vld_o,
  output logic [63:0]      srr1_o,
  output logic             srr1_vld_o,
  output logic [63:0]      nia_o,
  output logic             nia_vld_o
);
  localparam int NOUT = 4;

  entry_state_t nxt_q, nxt_d;
  logic [NOUT-1:0] vld_q;

  exc_msr_gen #(.UND_BIT(UND_BIT)) u_msr (
    .msr_i (msr_i),
    .msr_o (nxt_d.msr)
  );

  exc_srr1_gen u_srr1 (
    .kind_i  (kind_i),
    .msr_i   (msr_i),
    .cause_i (cause_i),
    .srr1_o  (nxt_d.srr1)
  );

  exc_addr_gen #(.VEC_W(VEC_W)) u_addr (
    .kind_i (kind_i),
    .cia_i  (cia_i),
    .vec_i  (vec_i),
    .srr0_o (nxt_d.srr0),
    .nia_o  (nxt_d.nia)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q <= '0;
      vld_q <= '0;
    end else begin
      vld_q <= {NOUT{entry_vld_i}};
      if (entry_vld_i) nxt_q <= nxt_d;
    end
  end

  assign msr_o      = nxt_q.msr;
  assign srr0_o     = nxt_q.srr0;
  assign srr1_o     = nxt_q.srr1;
  assign nia_o      = nxt_q.nia;
  assign msr_vld_o  = vld_q[0];
  assign srr0_vld_o = vld_q[1];
  assign srr1_vld_o = vld_q[2];
  assign nia_vld_o  = vld_q[3];
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int VEC_W   = 60,
  parameter int UND_BIT = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             entry_vld_i,
  input logic             kind_i,
  input logic [63:0]      msr_i,
  input logic [63:0]      cia_i,
  input logic [4:0]       cause_i,
  input logic [VEC_W-1:0] vec_i,
  input logic [63:0]      msr_o,
  input logic             msr_vld_o,
  input logic [63:0]      srr0_o,
  input logic             srr0_vld_o,
  input logic [63:0]      srr1_o,
  input logic             srr1_vld_o,
  input logic [63:0]      nia_o,
  input logic             nia_vld_o
);
  logic [63:0] zero_pos;

  always_comb begin
    zero_pos = '0;
    foreach (zero_pos[i]) begin
      if (i == 63 - 31 || i == 63 - 38 || i == 63 - 40 || i == 63 - 48 || i == 63 - 49 ||
          i == 63 - 50 || i == 63 - 52 || i == 63 - 53 || i == 63 - 54 || i == 63 - 55 ||
          i == 63 - 58 || i == 63 - 59 || i == 63 - 61 || i == 63 - 62 || i == 63 - UND_BIT)
        zero_pos[i] = 1'b1;
    end
  end

  p_msr_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_vld_o |-> ((msr_o & zero_pos) == 64'd0));

  p_msr_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_vld_o |-> (msr_o[63] && msr_o[0]));

  p_srr0_trap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_vld_i && !kind_i) |=> (srr0_o == $past(cia_i)));

  p_srr0_sc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_vld_i && kind_i) |=> (srr0_o == $past(cia_i) + 64'd4));

  p_plain_trap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_vld_i && !kind_i) |=> (srr1_o[63-46] == ($past(cause_i) == 5'd0)));

  p_sc_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_vld_i && kind_i) |=> (srr1_o[30:27] == 4'd0 && srr1_o[21:16] == 6'd0));

  p_nia_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_vld_i |=> (nia_o == (64'($past(vec_i)) << 4)));

  p_vld_on_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_vld_i |=> (msr_vld_o && srr0_vld_o && srr1_vld_o && nia_vld_o));

  p_vld_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry_vld_i |=> !(msr_vld_o || srr0_vld_o || srr1_vld_o || nia_vld_o));
endmodule

bind exc_entry_gen exc_entry_chk #(.VEC_W(VEC_W), .UND_BIT(UND_BIT)) u_chk (.*);

// File: tb/sim_exc_entry_gen.sv
`timescale 1ns/1ps
module sim_exc_entry_gen;
  localparam int VEC_W = 60;
  localparam int UND   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev = 1'b0, kind = 1'b0;
  logic [63:0] msr = '0, cia = '0;
  logic [4:0] cause = '0;
  logic [VEC_W-1:0] vec = '0;
  logic [63:0] msr_o, srr0_o, srr1_o, nia_o;
  logic msr_v, srr0_v, srr1_v, nia_v;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  exc_entry_gen #(.VEC_W(VEC_W), .UND_BIT(UND)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .entry_vld_i(ev), .kind_i(kind),
    .msr_i(msr), .cia_i(cia), .cause_i(cause), .vec_i(vec),
    .msr_o(msr_o), .msr_vld_o(msr_v), .srr0_o(srr0_o), .srr0_vld_o(srr0_v),
    .srr1_o(srr1_o), .srr1_vld_o(srr1_v), .nia_o(nia_o), .nia_vld_o(nia_v)
  );

  function automatic logic [63:0] e_msr(input logic [63:0] m);
    int clr[15] = '{31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 61, 62, UND};
    logic [63:0] r = m;
    foreach (clr[k]) r[63 - clr[k]] = 1'b0;
    r[63] = 1'b1;
    r[0]  = 1'b1;
    return r;
  endfunction

  function automatic logic [63:0] e_srr1(input logic k, input logic [63:0] m, input logic [4:0] c);
    logic [63:0] r = m;
    for (int n = 33; n <= 36; n++) r[63 - n] = 1'b0;
    for (int n = 42; n <= 47; n++) r[63 - n] = 1'b0;
    if (!k) begin
      r[63 - 43] = c[0];
      r[63 - 44] = c[4];
      r[63 - 45] = c[1];
      r[63 - 46] = (c == 5'd0);
      r[63 - 47] = c[3];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic entry(input logic k, input logic [63:0] m, input logic [63:0] a,
                       input logic [4:0] c, input logic [VEC_W-1:0] v);
    @(negedge clk);
    ev = 1'b1; kind = k; msr = m; cia = a; cause = c; vec = v;
    @(posedge clk); #1;
    chk("R1 R2 R3 msr", msr_o, e_msr(m));
    chk(k ? "R5 srr0" : "R4 srr0", srr0_o, k ? a + 64'd4 : a);
    chk(k ? "R8 srr1" : "R6 R7 srr1", srr1_o, e_srr1(k, m, c));
    chk("R9 nia", nia_o, 64'(v) << 4);
    chk("R10 vld on", {60'd0, msr_v, srr0_v, srr1_v, nia_v}, 64'hf);
  endtask

  task automatic idle();
    @(negedge clk);
    ev = 1'b0; msr = '1; cia = '1;
    @(posedge clk); #1;
    chk("R10 vld off", {60'd0, msr_v, srr0_v, srr1_v, nia_v}, 64'h0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    #1;
    chk("R10 reset", {60'd0, msr_v, srr0_v, srr1_v, nia_v}, 64'h0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle();
    entry(1'b0, '1, 64'h0000_0000_0000_1000, 5'd0, 60'h70);
    entry(1'b1, '1, '1, 5'h1f, '1);
    entry(1'b1, '0, 64'hffff_ffff_ffff_fffc, 5'd0, 60'hc0);
    entry(1'b0, '0, 64'h1234, 5'b00100, 60'h1);
    entry(1'b0, '1, 64'h8, 5'b11011, '0);
    idle();
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 4) == 0) idle();
      else entry(1'(($urandom())), {$urandom(), $urandom()}, {$urandom(), $urandom()},
                 5'($urandom()), VEC_W'({$urandom(), $urandom()}));
    end
    idle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule